// File: doc/BRIEF.md
# Card Command Issue and Response Controller

This block is the register-facing command path of a memory-card host controller. Software loads a 32-bit argument, then writes a command word with its start bit set. The block takes that command into execution at once if nothing is running. If a command is already running, the new one waits in a single-entry buffer. A third start while both places are occupied is refused and raises a lock-error status bit. Accepted commands go to a downstream command engine as index, argument and flag fields. The engine later reports completion with a 128-bit response and four error flags.

On completion the block raises a done status bit and copies the engine's error flags into separate status bits. It stores the response in four 32-bit response registers: all four for a long response, only the lowest for a short one. A command marked as a clock-update-only command never reaches the engine; it completes on its own one cycle after acceptance. The clock parameter register refuses writes while any command is executing or buffered. Status bits are write-1-to-clear and drive a single interrupt line through an enable mask.

The issue side toward the engine is a valid/ready stream. `eng_valid` is held, with index, argument and flags stable, until the engine raises `eng_ready` in the same cycle. The response side has no back-pressure: `eng_resp_valid` is a one-cycle strobe, taken only after that command's issue handshake, and ignored at any other time.

Top module: `cardcmd_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `eng_valid` is 0. Word addresses: argument 0, command 1, clock parameters 2, status 3, interrupt enable 4, response words 8 to 11 (lowest word at 8). Command word fields: [5:0] index, [6] response expected, [7] long response, [8] data expected, [9] clock-update-only, [31] start. Status bits: [0] done, [1] response timeout, [2] response CRC error, [3] response error, [4] boot acknowledge, [5] lock error.
- R2: A start written while nothing executes and nothing is buffered is accepted at that clock edge. From the next cycle the command word reads start = 0, and `eng_valid` is high with the written index and flags. These outputs hold steady until `eng_ready`.
- R3: A start written while a command executes is buffered. The command word reads start = 1 until the buffered command moves into execution. It is issued to the engine only after the running command completes, and it keeps its order behind that command.
- R4: A start written while one command executes and another is buffered is dropped and is never issued. Status bit 5 is set, and the buffered command's index and start bit are unchanged.
- R5: When the engine's response strobe arrives, status bit 0 is set. Status bits 1 to 4 are set from the engine's timeout, CRC, response-error and boot-acknowledge flags.
- R6: For a command with the response-expected and long flags set, response word n takes engine response bits [32n+31:32n]. Bit 31 of word 11 is the response MSB and bit 0 of word 8 its LSB.
- R7: A short response writes only word 8; words 9 to 11 keep their contents. A completion with the timeout flag set writes no response word.
- R8: A command with the clock-update-only flag is never issued to the engine; it sets status bit 0 shortly after acceptance.
- R9: Writes to the clock parameter register are ignored while a command is executing or buffered, and take effect when the path is idle.
- R10: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit is set whose interrupt-enable bit (same position) is 1.
- R12: The argument is captured when the command is taken into execution or into the buffer. Rewriting the argument register afterwards does not change what the engine receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_valid | output | 1 | Command issue valid |
| eng_ready | input | 1 | Engine accepts the issued command |
| eng_index | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_resp_expect | output | 1 | Response expected flag |
| eng_resp_long | output | 1 | Long response flag |
| eng_data_expect | output | 1 | Data phase flag |
| eng_resp_valid | input | 1 | Completion strobe |
| eng_resp_timeout | input | 1 | Response timeout flag |
| eng_resp_crc_err | input | 1 | Response CRC error flag |
| eng_resp_err | input | 1 | Response error flag |
| eng_boot_ack | input | 1 | Boot acknowledge received |
| eng_resp_data | input | 128 | Response bits, MSB at 127 |
| clk_cfg | output | 32 | Current clock parameter register |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong occupancy state in the acceptance logic shows up at the ports within a few cycles. It can appear as a start bit that reads back wrongly on the next read, as a command issued out of order or twice, or as a lock error that is missing or spurious. A stuck or mis-sequenced execution state shows as `eng_valid` never rising, or as a done bit that never sets. A wrong capture path shows as response words overwritten or left stale, and this is visible on the first read after completion. The scoreboard pairs every engine handshake with the command software expected to be issued, so extra or reordered issues are caught at the handshake itself.

// File: rtl/cardcmd_pkg.sv
package cardcmd_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = 6;
  localparam int RESP_WORDS = 4;
  localparam int ADDR_W     = 4;
  localparam int ST_W       = 6;

  // register word addresses
  localparam logic [ADDR_W-1:0] REG_ARG   = 4'd0;
  localparam logic [ADDR_W-1:0] REG_CMD   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_CLK   = 4'd2;
  localparam logic [ADDR_W-1:0] REG_STS   = 4'd3;
  localparam logic [ADDR_W-1:0] REG_INTEN = 4'd4;
  localparam logic [ADDR_W-1:0] REG_RESP0 = 4'd8;

  // command word bit positions
  localparam int CB_RESP    = 6;
  localparam int CB_LONG    = 7;
  localparam int CB_DATA    = 8;
  localparam int CB_CLKONLY = 9;
  localparam int CB_START   = 31;
  localparam int CMD_KEEP_W = CB_CLKONLY + 1;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_TO   = 1;
  localparam int ST_CRC  = 2;
  localparam int ST_RERR = 3;
  localparam int ST_BOOT = 4;
  localparam int ST_LOCK = 5;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic              resp_exp;
    logic              resp_long;
    logic              data_exp;
    logic              clk_only;
    logic [WORD_W-1:0] arg;
  } cmd_t;

  typedef enum logic [1:0] {EX_IDLE, EX_ISSUE, EX_WAIT, EX_CLKUPD} ex_state_e;

  function automatic cmd_t pack_cmd(input logic [WORD_W-1:0] word,
                                    input logic [WORD_W-1:0] arg);
    cmd_t c;
    c.idx       = word[IDX_W-1:0];
    c.resp_exp  = word[CB_RESP];
    c.resp_long = word[CB_LONG];
    c.data_exp  = word[CB_DATA];
    c.clk_only  = word[CB_CLKONLY];
    c.arg       = arg;
    return c;
  endfunction
endpackage

// File: rtl/cardcmd_queue.sv
module cardcmd_queue
  import cardcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  cmd_t new_cmd,
  input  logic exec_busy,
  output logic load,
  output cmd_t load_cmd,
  output logic buf_valid,
  output logic lock_pulse
);
  cmd_t buf_q;
  logic buf_v;
  logic promote, direct, to_buf;

  // buffered command moves on only once the executor is free
  assign promote    = !exec_busy && buf_v;
  assign direct     = start_req && !exec_busy && !buf_v;
  assign to_buf     = start_req && (exec_busy ? !buf_v : buf_v);
  assign lock_pulse = start_req && exec_busy && buf_v;
  assign load       = direct || promote;
  assign load_cmd   = promote ? buf_q : new_cmd;
  assign buf_valid  = buf_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v <= 1'b0;
      buf_q <= '0;
    end else if (to_buf) begin
      buf_v <= 1'b1;
      buf_q <= new_cmd;
    end else if (promote) begin
      buf_v <= 1'b0;
    end
  end
endmodule

// File: rtl/cardcmd_exec.sv
module cardcmd_exec
  import cardcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  cmd_t              load_cmd,
  output logic              busy,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [IDX_W-1:0]  eng_index,
  output logic [WORD_W-1:0] eng_arg,
  output logic              eng_resp_expect,
  output logic              eng_resp_long,
  output logic              eng_data_expect,
  input  logic              eng_resp_valid,
  output logic              done,
  output logic              resp_done,
  output logic              cur_resp_exp,
  output logic              cur_long
);
  ex_state_e state;
  cmd_t      cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= EX_IDLE;
      cmd_q <= '0;
    end else begin
      unique case (state)
        EX_IDLE: if (load) begin
          cmd_q <= load_cmd;
          state <= load_cmd.clk_only ? EX_CLKUPD : EX_ISSUE;
        end
        EX_ISSUE:  if (eng_ready) state <= EX_WAIT;
        EX_WAIT:   if (eng_resp_valid) state <= EX_IDLE;
        EX_CLKUPD: state <= EX_IDLE;
        default:   state <= EX_IDLE;
      endcase
    end
  end

  assign busy            = (state != EX_IDLE);
  assign eng_valid       = (state == EX_ISSUE);
  assign eng_index       = cmd_q.idx;
  assign eng_arg         = cmd_q.arg;
  assign eng_resp_expect = cmd_q.resp_exp;
  assign eng_resp_long   = cmd_q.resp_long;
  assign eng_data_expect = cmd_q.data_exp;
  assign resp_done       = (state == EX_WAIT) && eng_resp_valid;
  assign done            = resp_done || (state == EX_CLKUPD);
  assign cur_resp_exp    = cmd_q.resp_exp;
  assign cur_long        = cmd_q.resp_long;
endmodule

// File: rtl/cardcmd_status.sv
module cardcmd_status
  import cardcmd_pkg::*;
#(
  parameter int NWORDS = RESP_WORDS,
  localparam int RESP_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              resp_done,
  input  logic              r_timeout,
  input  logic              r_crc,
  input  logic              r_err,
  input  logic              r_boot,
  input  logic              lock_pulse,
  input  logic              resp_exp,
  input  logic              resp_long,
  input  logic [RESP_W-1:0] resp_data,
  input  logic              w1c_en,
  input  logic [ST_W-1:0]   w1c_mask,
  input  logic [ST_W-1:0]   inten,
  output logic [ST_W-1:0]   sts,
  output logic [RESP_W-1:0] resp_words,
  output logic              irq
);
  logic [ST_W-1:0] set_v, clr_v;
  logic            capture;

  always_comb begin
    set_v          = '0;
    set_v[ST_DONE] = done;
    set_v[ST_TO]   = resp_done && r_timeout;
    set_v[ST_CRC]  = resp_done && r_crc;
    set_v[ST_RERR] = resp_done && r_err;
    set_v[ST_BOOT] = resp_done && r_boot;
    set_v[ST_LOCK] = lock_pulse;
    clr_v          = w1c_en ? w1c_mask : '0;
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_v) | set_v;
  end

  assign capture = resp_done && resp_exp && !r_timeout;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic wr_this;
    if (w == 0) begin : g_low
      assign wr_this = capture;
    end else begin : g_high
      assign wr_this = capture && resp_long;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       resp_words[w*WORD_W +: WORD_W] <= '0;
      else if (wr_this) resp_words[w*WORD_W +: WORD_W] <= resp_data[w*WORD_W +: WORD_W];
    end
  end

  assign irq = |(sts & inten);
endmodule

// File: rtl/cardcmd_ctrl.sv
module cardcmd_ctrl
  import cardcmd_pkg::*;
#(
  parameter int NWORDS = RESP_WORDS,
  localparam int RESP_W = NWORDS * WORD_W,
  localparam int RIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [IDX_W-1:0]  eng_index,
  output logic [WORD_W-1:0] eng_arg,
  output logic              eng_resp_expect,
  output logic              eng_resp_long,
  output logic              eng_data_expect,
  input  logic              eng_resp_valid,
  input  logic              eng_resp_timeout,
  input  logic              eng_resp_crc_err,
  input  logic              eng_resp_err,
  input  logic              eng_boot_ack,
  input  logic [RESP_W-1:0] eng_resp_data,
  output logic [WORD_W-1:0] clk_cfg,
  output logic              irq
);
  logic [WORD_W-1:0]     arg_q;
  logic [CMD_KEEP_W-1:0] cmd_shadow;
  logic [WORD_W-1:0]     clk_q;
  logic [ST_W-1:0]       inten_q;

  logic cmd_wr, clk_wr, start_req;
  logic load, buf_valid, lock_pulse, exec_busy;
  logic exec_done, resp_done, cur_resp_exp, cur_long;
  cmd_t new_cmd, load_cmd;
  logic [ST_W-1:0]   sts;
  logic [RESP_W-1:0] resp_words;
  logic [ADDR_W-1:0] roff;

  assign cmd_wr    = reg_wr_en && (reg_addr == REG_CMD);
  assign clk_wr    = reg_wr_en && (reg_addr == REG_CLK);
  assign start_req = cmd_wr && reg_wdata[CB_START];
  assign new_cmd   = pack_cmd(reg_wdata, arg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q      <= '0;
      cmd_shadow <= '0;
      clk_q      <= '0;
      inten_q    <= '0;
    end else if (reg_wr_en) begin
      if (reg_addr == REG_ARG)   arg_q   <= reg_wdata;
      if (reg_addr == REG_INTEN) inten_q <= reg_wdata[ST_W-1:0];
      if (cmd_wr && !lock_pulse) cmd_shadow <= reg_wdata[CMD_KEEP_W-1:0];
      if (clk_wr && !exec_busy && !buf_valid) clk_q <= reg_wdata;
    end
  end

  cardcmd_queue u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .new_cmd    (new_cmd),
    .exec_busy  (exec_busy),
    .load       (load),
    .load_cmd   (load_cmd),
    .buf_valid  (buf_valid),
    .lock_pulse (lock_pulse)
  );

  cardcmd_exec u_exec (
    .clk             (clk),
    .rst_n           (rst_n),
    .load            (load),
    .load_cmd        (load_cmd),
    .busy            (exec_busy),
    .eng_valid       (eng_valid),
    .eng_ready       (eng_ready),
    .eng_index       (eng_index),
    .eng_arg         (eng_arg),
    .eng_resp_expect (eng_resp_expect),
    .eng_resp_long   (eng_resp_long),
    .eng_data_expect (eng_data_expect),
    .eng_resp_valid  (eng_resp_valid),
    .done            (exec_done),
    .resp_done       (resp_done),
    .cur_resp_exp    (cur_resp_exp),
    .cur_long        (cur_long)
  );

  cardcmd_status #(.NWORDS(NWORDS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (exec_done),
    .resp_done  (resp_done),
    .r_timeout  (eng_resp_timeout),
    .r_crc      (eng_resp_crc_err),
    .r_err      (eng_resp_err),
    .r_boot     (eng_boot_ack),
    .lock_pulse (lock_pulse),
    .resp_exp   (cur_resp_exp),
    .resp_long  (cur_long),
    .resp_data  (eng_resp_data),
    .w1c_en     (reg_wr_en && (reg_addr == REG_STS)),
    .w1c_mask   (reg_wdata[ST_W-1:0]),
    .inten      (inten_q),
    .sts        (sts),
    .resp_words (resp_words),
    .irq        (irq)
  );

  assign clk_cfg = clk_q;
  assign roff    = reg_rd_addr - REG_RESP0;

  always_comb begin
    reg_rdata = '0;
    case (reg_rd_addr)
      REG_ARG:   reg_rdata = arg_q;
      REG_CMD: begin
        reg_rdata[CMD_KEEP_W-1:0] = cmd_shadow;
        reg_rdata[CB_START]       = buf_valid;
      end
      REG_CLK:   reg_rdata = clk_q;
      REG_STS:   reg_rdata[ST_W-1:0] = sts;
      REG_INTEN: reg_rdata[ST_W-1:0] = inten_q;
      default:
        if (roff < ADDR_W'(NWORDS))
          reg_rdata = resp_words[roff[RIDX_W-1:0]*WORD_W +: WORD_W];
    endcase
  end
endmodule

// File: rtl/cardcmd_ctrl_chk.sv
module cardcmd_ctrl_chk
  import cardcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              exec_busy,
  input logic              buf_valid,
  input logic              lock_pulse,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic [IDX_W-1:0]  eng_index,
  input logic [WORD_W-1:0] eng_arg,
  input logic              exec_done,
  input logic [ST_W-1:0]   sts,
  input logic [WORD_W-1:0] clk_cfg,
  input logic              clk_wr,
  input logic              irq
);
  AST_ISSUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_index) && $stable(eng_arg)); // R2
  AST_BUF_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !exec_busy |=> exec_busy); // R3
  AST_LOCK_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |-> exec_busy && buf_valid); // R4
  AST_LOCK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> sts[ST_LOCK]); // R4
  AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    exec_done |=> sts[ST_DONE]); // R5
  AST_CLK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_wr && (exec_busy || buf_valid) |=> $stable(clk_cfg)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !irq); // R11
endmodule

bind cardcmd_ctrl cardcmd_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_busy  (exec_busy),
  .buf_valid  (buf_valid),
  .lock_pulse (lock_pulse),
  .eng_valid  (eng_valid),
  .eng_ready  (eng_ready),
  .eng_index  (eng_index),
  .eng_arg    (eng_arg),
  .exec_done  (exec_done),
  .sts        (sts),
  .clk_cfg    (clk_cfg),
  .clk_wr     (clk_wr),
  .irq        (irq)
);

// File: tb/cardcmd_ctrl_tb.sv
`timescale 1ns/1ps
module cardcmd_ctrl_tb;
  import cardcmd_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [3:0]    reg_rd_addr = '0;
  logic [31:0]   reg_rdata;
  logic          eng_valid, eng_ready = 1'b0;
  logic [5:0]    eng_index;
  logic [31:0]   eng_arg;
  logic          eng_resp_expect, eng_resp_long, eng_data_expect;
  logic          eng_resp_valid = 1'b0;
  logic          eng_resp_timeout = 1'b0, eng_resp_crc_err = 1'b0;
  logic          eng_resp_err = 1'b0, eng_boot_ack = 1'b0;
  logic [127:0]  eng_resp_data = '0;
  logic [31:0]   clk_cfg;
  logic          irq;

  cardcmd_ctrl u_dut (.*);

  int checks = 0, errors = 0, issued = 0;
  bit finished = 1'b0;
  typedef struct { logic [5:0] idx; logic [31:0] arg; } exp_t;
  exp_t expq[$];
  int eng_lat = 2;
  logic r_to = 0, r_crc = 0, r_err = 0, r_boot = 0;
  logic [127:0] r_data = '0;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: pushes the command expected at the engine, then starts it
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                       input logic [31:0] flags, input bit expect_issue);
    wr(REG_ARG, arg);
    if (expect_issue) expq.push_back('{idx, arg});
    wr(REG_CMD, 32'h8000_0000 | flags | {26'b0, idx});
  endtask

  task automatic wait_done();
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 300; i++) begin
      rd(REG_STS, s);
      if (s[0]) break;
      @(negedge clk);
    end
    check("R5", {31'b0, s[0]}, 32'h1, "done bit");
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (eng_valid === 1'b1) begin
        issued++;
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4/R8 unexpected issue: actual idx %h expected none", eng_index);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check("R2/R3", {26'b0, eng_index}, {26'b0, e.idx}, "issued index");
          check("R12", eng_arg, e.arg, "issued argument");
        end
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
        repeat (eng_lat) @(negedge clk);
        eng_resp_timeout = r_to; eng_resp_crc_err = r_crc;
        eng_resp_err = r_err; eng_boot_ack = r_boot;
        eng_resp_data = r_data; eng_resp_valid = 1'b1;
        @(negedge clk);
        eng_resp_valid = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [127:0] long_d, short_d;
    int base;
    long_d  = 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
    short_d = 128'h1111_2222_3333_4444_5555_6666_CAFE_F00D;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(REG_STS, v);   check("R1", v, 32'h0, "status after reset");
    rd(REG_CMD, v);   check("R1", v, 32'h0, "command after reset");
    rd(REG_RESP0, v); check("R1", v, 32'h0, "resp0 after reset");
    check("R1", {31'b0, irq}, 32'h0, "irq after reset");
    check("R1", {31'b0, eng_valid}, 32'h0, "eng_valid after reset");

    // R9 idle clock write takes effect
    wr(REG_CLK, 32'h11);
    rd(REG_CLK, v); check("R9", v, 32'h11, "clock write when idle");

    // R2 R6 R12 long response
    r_data = long_d;
    issue(6'd5, 32'hA1A1_0001, 32'h0000_00C0, 1'b1);
    rd(REG_CMD, v); check("R2", {31'b0, v[31]}, 32'h0, "start cleared on accept");
    check("R2", {31'b0, eng_valid}, 32'h1, "issue valid after accept");
    wr(REG_ARG, 32'hDEAD_BEEF); // R12 rewrite after acceptance
    wait_done();
    for (int i = 0; i < 4; i++) begin
      rd(REG_RESP0 + 4'(i), v); check("R6", v, long_d[i*32 +: 32], "long response word");
    end
    rd(4'd11, v); check("R6", {31'b0, v[31]}, {31'b0, long_d[127]}, "response MSB");
    wr(REG_STS, 32'h3F);
    rd(REG_STS, v); check("R10", v, 32'h0, "status cleared by write-1");

    // R7 short response leaves upper words
    r_data = short_d;
    issue(6'd17, 32'h0000_0042, 32'h0000_0040, 1'b1);
    wait_done();
    rd(REG_RESP0, v); check("R7", v, short_d[31:0], "short response word 0");
    for (int i = 1; i < 4; i++) begin
      rd(REG_RESP0 + 4'(i), v); check("R7", v, long_d[i*32 +: 32], "upper word kept");
    end
    wr(REG_STS, 32'h3F);

    // R5 CRC error, R11 irq, R10 partial clear
    r_crc = 1'b1;
    issue(6'd2, 32'h0, 32'h0000_0040, 1'b1);
    wait_done();
    rd(REG_STS, v); check("R5", v, 32'h5, "done plus crc flag");
    check("R11", {31'b0, irq}, 32'h0, "irq masked");
    wr(REG_INTEN, 32'h4);
    check("R11", {31'b0, irq}, 32'h1, "irq when crc enabled");
    wr(REG_STS, 32'h4);
    rd(REG_STS, v); check("R10", v, 32'h1, "only written bit cleared");
    check("R11", {31'b0, irq}, 32'h0, "irq drops after clear");
    wr(REG_STS, 32'h3F); wr(REG_INTEN, 32'h0);

    // R7 timeout: no capture
    r_crc = 1'b0; r_to = 1'b1; r_data = ~short_d;
    issue(6'd3, 32'h0, 32'h0000_0040, 1'b1);
    wait_done();
    rd(REG_STS, v);   check("R5", v, 32'h3, "done plus timeout");
    rd(REG_RESP0, v); check("R7", v, short_d[31:0], "no capture on timeout");
    wr(REG_STS, 32'h3F);

    // R5 error and boot-ack flags
    r_to = 1'b0; r_err = 1'b1; r_boot = 1'b1;
    issue(6'd4, 32'h0, 32'h0000_0040, 1'b1);
    wait_done();
    rd(REG_STS, v); check("R5", v, 32'h19, "done, resp error, boot ack");
    wr(REG_STS, 32'h3F);
    r_err = 1'b0; r_boot = 1'b0;

    // R3 R4 R9 buffering and lock
    eng_lat = 20;
    base = issued;
    issue(6'd10, 32'hAAAA_0010, 32'h0000_0100, 1'b1);
    issue(6'd11, 32'hBBBB_0011, 32'h0, 1'b1);
    rd(REG_CMD, v); check("R3", {31'b0, v[31]}, 32'h1, "start held while buffered");
    wr(REG_CLK, 32'h55);
    rd(REG_CLK, v); check("R9", v, 32'h11, "clock write ignored while busy");
    issue(6'd12, 32'hCCCC_0012, 32'h0, 1'b0);
    rd(REG_STS, v); check("R4", {31'b0, v[5]}, 32'h1, "lock error set");
    rd(REG_CMD, v); check("R4", {26'b0, v[5:0]}, 32'd11, "buffered index kept");
    check("R4", {31'b0, v[31]}, 32'h1, "buffered start kept");
    repeat (80) @(negedge clk);
    rd(REG_CMD, v); check("R3", {31'b0, v[31]}, 32'h0, "start cleared after promotion");
    check("R3", issued - base, 32'd2, "two commands issued");
    check("R3", expq.size(), 32'd0, "scoreboard drained");
    wr(REG_CLK, 32'h77);
    rd(REG_CLK, v); check("R9", v, 32'h77, "clock write after idle");
    wr(REG_STS, 32'h3F);
    eng_lat = 2;

    // R8 clock-update-only command bypasses engine
    base = issued;
    issue(6'd0, 32'h0, 32'h0000_0200, 1'b0);
    repeat (5) @(negedge clk);
    rd(REG_STS, v); check("R8", v, 32'h1, "clock-only sets done");
    check("R8", issued - base, 32'd0, "clock-only not issued");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule